// File: doc/BRIEF.md
# Control Echo Responder

This block is the device-side half of a two-step control handshake on a serial port. While the data/control input is low, the controller sends 64-bit control words. Each word opens with a time-slot pulse sampled on a serial clock rising edge. In the same frame the block sends back an echo: the last control word it accepted, with the handshake flag replaced by the value it currently acknowledges. A new handshake flag value is acknowledged in the very next frame only when the internal oscillator is selected and the clock fields did not change in the last word. Otherwise the acknowledgement waits until a stability timer shows that the rate and source fields have been held long enough.

Once a word with the handshake flag set has been taken in, the configuration freezes and later words are ignored. The block sends one full echo frame that carries the set flag, waits one more serial clock, and then turns its serial output driver off. When data/control rises, data mode starts. As clock master the block generates a serial clock and a frame sync with one lead-in clock period. As slave it flags the first rising time-slot input, even on the very first serial clock edge. Reset or power-down clears everything.

The serial clock edges are supplied as a one-cycle enable (`sclk_rise`) in the system clock domain. Word bit 63 travels first. Field positions: handshake flag bit 61, sample rate bits 55:53, clock source bits 52:51 (00 internal oscillator, 01 serial clock, 10 external clock input), clock master bit 50.

Top module: `cw_echo_responder`

## Requirements
- R1: In control mode, a frame starts at a `sclk_rise` cycle with `tsin` high. The bit received on that edge and on each of the next 63 edges are word bits 63 down to 0. After the k-th edge of the frame (k from 0), `sdo` shows bit 63-k of the echo word.
- R2: The echo word is the most recently accepted control word with bit 61 replaced by the acknowledged handshake value. After reset that word is all zero.
- R3: When the accepted word selects source 00 and its rate (55:53) and source (52:51) fields equal those of the word before it, a new bit 61 value is acknowledged in the echo of the next frame.
- R4: In any other case a new bit 61 value is acknowledged only in a frame that starts at least STABLE_CYC clock cycles after the last change of the rate or source field.
- R5: The stability timer restarts whenever an accepted word changes the rate or source field.
- R6: Once a word with bit 61 set has been accepted, further control words have no effect on the configuration until data mode, reset or power-down.
- R7: After the frame whose echo carries bit 61 set has sent all 64 bits, `sdo_oe` goes low at the next `sclk_rise` and stays low while `dc` stays low.
- R8: Reset or power-down clears the configuration, the acknowledged flag and the lock. `sdo_oe` is low during reset and power-down.
- R9: Entering data mode with bit 50 set, `sclk_out` is low in the first cycle and then toggles every cycle. `fsync_out` rises with the second rising edge of `sclk_out`, stays high for one period and rises again every FRAME_SCLKS periods.
- R10: In data mode with bit 50 clear, `slot_start` pulses one cycle after a `sclk_rise` where `tsin` is high and was low at the previous `sclk_rise`. `tsin` counts as low before the first edge of data mode.
- R11: `sdo_oe` is low in data mode. Returning to control mode clears the acknowledged flag and the lock but keeps the configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down, synchronous clear |
| dc | input | 1 | High selects data mode, low selects control mode |
| sclk_rise | input | 1 | One-cycle marker of a serial clock rising edge |
| tsin | input | 1 | Time-slot / frame-start input |
| sdi | input | 1 | Serial control data in |
| sdo | output | 1 | Serial echo data out |
| sdo_oe | output | 1 | Output enable for sdo; low means three-stated |
| sclk_out | output | 1 | Generated serial clock in master data mode |
| fsync_out | output | 1 | Generated frame sync in master data mode |
| slot_start | output | 1 | Detected time-slot start in slave data mode |

## Verification
The hardest case to reach is the delayed acknowledgement: telling a restarted stability timer apart from one that kept running. From the ports this shows only as the flag bit of an echo several frames later. The stimulus selects a non-oscillator source and waits long enough that a timer which kept running would have expired. It then changes the rate field, sets the handshake flag, and times the next frame to start before the restarted timer can expire, followed by a second frame after it has expired. Checking the ignored words after the lock is also indirect. The ignored word sets the master bit, so the bench enters data mode and confirms that no serial clock appears.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
  localparam int unsigned CW_BITS  = 64;
  localparam int unsigned HS_POS   = 61;
  localparam int unsigned RATE_MSB = 55;
  localparam int unsigned RATE_LSB = 53;
  localparam int unsigned SRC_MSB  = 52;
  localparam int unsigned SRC_LSB  = 51;
  localparam int unsigned MST_POS  = 50;

  typedef enum logic [1:0] {
    CLK_OSC = 2'b00,
    CLK_SER = 2'b01,
    CLK_EXT = 2'b10,
    CLK_RSV = 2'b11
  } clk_src_e;
endpackage

// File: rtl/cwe_rst_sync.sv
module cwe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cwe_framer.sv
module cwe_framer #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_en,
  input  logic              tsin,
  input  logic              sdi,
  input  logic [WORD_W-1:0] tx_word,
  output logic              start,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word,
  output logic              tail,
  output logic              sdo
);
  localparam int unsigned CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] IDLE = CW'(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              run;

  always_comb begin
    start    = bit_en & tsin & ~clr;
    run      = bit_en & ~tsin & ~clr & (cnt_q != IDLE);
    rx_valid = run & (cnt_q == LAST);
    tail     = bit_en & ~clr & (cnt_q == IDLE);
    rx_word  = {rx_q[WORD_W-2:0], sdi};
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    if (clr) begin
      cnt_d = IDLE;
    end else if (start) begin
      cnt_d = ONE;
      rx_d  = {rx_q[WORD_W-2:0], sdi};
      tx_d  = tx_word;
    end else if (run) begin
      cnt_d = cnt_q + ONE;
      rx_d  = {rx_q[WORD_W-2:0], sdi};
      tx_d  = {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  assign sdo = tx_q[WORD_W-1];

  // R1
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sdo == $past(tx_word[WORD_W-1])));
endmodule

// File: rtl/cwe_hs.sv
module cwe_hs
  import cwe_pkg::*;
#(
  parameter int unsigned WORD_W     = 64,
  parameter int unsigned STABLE_CYC = 49152
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ctl_exit,
  input  logic              start,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              tail,
  output logic [WORD_W-1:0] tx_word,
  output logic              master,
  output logic              tri_off
);
  localparam int unsigned TW = $clog2(STABLE_CYC + 1);
  localparam logic [TW-1:0] TMAX = TW'(STABLE_CYC);
  localparam logic [TW-1:0] TONE = TW'(1);

  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic cand_q, cand_d, cons_q, cons_d, armed_q, armed_d;
  logic final_q, final_d, done_q, done_d, echo_q, echo_d;
  logic fld_chg, accept, stable, fast, echo_nx;

  always_comb begin
    fld_chg = (rx_word[RATE_MSB:RATE_LSB] != cfg_q[RATE_MSB:RATE_LSB]) ||
              (rx_word[SRC_MSB:SRC_LSB]   != cfg_q[SRC_MSB:SRC_LSB]);
    accept  = rx_valid & ~armed_q;
    stable  = (tmr_q == TMAX);
    fast    = (cfg_q[SRC_MSB:SRC_LSB] == CLK_OSC) && cons_q;
    echo_nx = (start && !final_q && (fast || stable)) ? cand_q : echo_q;
    tx_word = cfg_q;
    tx_word[HS_POS] = echo_nx;
  end

  always_comb begin
    cfg_d   = cfg_q;
    cand_d  = cand_q;
    cons_d  = cons_q;
    armed_d = armed_q;
    final_d = final_q;
    done_d  = done_q;
    echo_d  = echo_q;
    tmr_d   = stable ? tmr_q : tmr_q + TONE;
    if (clr) begin
      cfg_d   = '0;
      cand_d  = 1'b0;
      cons_d  = 1'b0;
      armed_d = 1'b0;
      final_d = 1'b0;
      done_d  = 1'b0;
      echo_d  = 1'b0;
      tmr_d   = '0;
    end else if (ctl_exit) begin
      cand_d  = 1'b0;
      armed_d = 1'b0;
      final_d = 1'b0;
      done_d  = 1'b0;
      echo_d  = 1'b0;
    end else begin
      echo_d = echo_nx;
      if (accept) begin
        cfg_d   = rx_word;
        cand_d  = rx_word[HS_POS];
        cons_d  = ~fld_chg;
        armed_d = rx_word[HS_POS];
        if (fld_chg) tmr_d = '0;
      end
      if (start && echo_nx && !final_q) final_d = 1'b1;
      if (final_q && tail) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      tmr_q   <= '0;
      cand_q  <= 1'b0;
      cons_q  <= 1'b0;
      armed_q <= 1'b0;
      final_q <= 1'b0;
      done_q  <= 1'b0;
      echo_q  <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      tmr_q   <= tmr_d;
      cand_q  <= cand_d;
      cons_q  <= cons_d;
      armed_q <= armed_d;
      final_q <= final_d;
      done_q  <= done_d;
      echo_q  <= echo_d;
    end
  end

  assign master  = cfg_q[MST_POS];
  assign tri_off = done_q;

  // R6
  ignore_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rx_valid && !clr && !ctl_exit) |=> $stable(cfg_q));

  // R7
  tristate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr && !ctl_exit) |=> done_q);

  // R3
  echo_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clr && !ctl_exit) |=> $stable(echo_q));

  // R4
  echo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(echo_q) |-> $past(fast || stable));
endmodule

// File: rtl/cwe_dmode.sv
module cwe_dmode #(
  parameter int unsigned FRAME_SCLKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dm_en,
  input  logic master,
  input  logic bit_en,
  input  logic tsin,
  output logic sclk_o,
  output logic fsync_o,
  output logic slot_o
);
  localparam int unsigned FW = $clog2(FRAME_SCLKS + 1);
  localparam logic [FW-1:0] FLAST = FW'(FRAME_SCLKS);
  localparam logic [FW-1:0] FONE  = FW'(1);

  logic          dm_q, dm_d, sclk_q, sclk_d, fsync_q, fsync_d;
  logic          tsin_q, tsin_d, slot_q, slot_d;
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    dm_d    = dm_q;
    sclk_d  = sclk_q;
    fsync_d = fsync_q;
    cnt_d   = cnt_q;
    tsin_d  = tsin_q;
    slot_d  = 1'b0;
    if (!dm_en) begin
      dm_d    = 1'b0;
      sclk_d  = 1'b0;
      fsync_d = 1'b0;
      cnt_d   = '0;
      tsin_d  = 1'b0;
    end else begin
      dm_d = 1'b1;
      if (master) begin
        if (!dm_q) begin
          sclk_d  = 1'b0;
          fsync_d = 1'b0;
          cnt_d   = '0;
        end else begin
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            fsync_d = (cnt_q == FONE);
            cnt_d   = (cnt_q == FLAST) ? FONE : cnt_q + FONE;
          end
        end
      end else begin
        slot_d = bit_en & tsin & ~tsin_q;
        if (bit_en) tsin_d = tsin;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q    <= 1'b0;
      sclk_q  <= 1'b0;
      fsync_q <= 1'b0;
      cnt_q   <= '0;
      tsin_q  <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      dm_q    <= dm_d;
      sclk_q  <= sclk_d;
      fsync_q <= fsync_d;
      cnt_q   <= cnt_d;
      tsin_q  <= tsin_d;
      slot_q  <= slot_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign fsync_o = fsync_q;
  assign slot_o  = slot_q;

  // R9
  fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_q) |-> (sclk_q && !$past(sclk_q)));

  // R9
  fsync_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_q |-> (master && dm_q));

  // R10
  slot_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q |-> !master);
endmodule

// File: rtl/cw_echo_responder.sv
module cw_echo_responder #(
  parameter int unsigned WORD_W      = cwe_pkg::CW_BITS,
  parameter int unsigned STABLE_CYC  = 49152,
  parameter int unsigned FRAME_SCLKS = 64,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic dc,
  input  logic sclk_rise,
  input  logic tsin,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  output logic sclk_out,
  output logic fsync_out,
  output logic slot_start
);
  logic              rst_ni;
  logic              f_start, f_valid, f_tail;
  logic [WORD_W-1:0] f_rx, f_tx;
  logic              hs_master, hs_off;

  cwe_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_ni)
  );

  cwe_framer #(.WORD_W(WORD_W)) frm_i (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr      (pdn | dc),
    .bit_en   (sclk_rise),
    .tsin     (tsin),
    .sdi      (sdi),
    .tx_word  (f_tx),
    .start    (f_start),
    .rx_valid (f_valid),
    .rx_word  (f_rx),
    .tail     (f_tail),
    .sdo      (sdo)
  );

  cwe_hs #(.WORD_W(WORD_W), .STABLE_CYC(STABLE_CYC)) hs_i (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr      (pdn),
    .ctl_exit (dc),
    .start    (f_start),
    .rx_valid (f_valid),
    .rx_word  (f_rx),
    .tail     (f_tail),
    .tx_word  (f_tx),
    .master   (hs_master),
    .tri_off  (hs_off)
  );

  cwe_dmode #(.FRAME_SCLKS(FRAME_SCLKS)) dm_i (
    .clk     (clk),
    .rst_n   (rst_ni),
    .dm_en   (dc & ~pdn),
    .master  (hs_master),
    .bit_en  (sclk_rise),
    .tsin    (tsin),
    .sclk_o  (sclk_out),
    .fsync_o (fsync_out),
    .slot_o  (slot_start)
  );

  assign sdo_oe = rst_ni & ~dc & ~pdn & ~hs_off;
endmodule

// File: tb/cw_echo_responder_tb_top.sv
module cw_echo_responder_tb_top;
  localparam int unsigned STB = 400;
  localparam int unsigned FRM = 8;

  logic clk = 1'b0;
  logic rst_n, pdn, dc, sclk_rise, tsin, sdi;
  logic sdo, sdo_oe, sclk_out, fsync_out, slot_start;
  int   n_chk = 0;
  int   n_err = 0;
  bit   ended = 1'b0;

  always #2 clk = ~clk;

  cw_echo_responder #(.STABLE_CYC(STB), .FRAME_SCLKS(FRM)) dut_i (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .dc(dc), .sclk_rise(sclk_rise),
    .tsin(tsin), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .sclk_out(sclk_out),
    .fsync_out(fsync_out), .slot_start(slot_start)
  );

  localparam logic [63:0] TAB_TX [4] = '{
    64'h8003_A5A5_1234_5678, 64'h4000_0000_0000_00FF,
    64'hC003_0F0F_F0F0_55AA, 64'h0001_FFFF_0000_FFFF};
  localparam logic [63:0] TAB_EXP [4] = '{
    64'h0, 64'h8003_A5A5_1234_5678,
    64'h4000_0000_0000_00FF, 64'hC003_0F0F_F0F0_55AA};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [63:0] w, output logic [63:0] echo);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      sclk_rise = 1'b1; tsin = (k == 0); sdi = w[63-k];
      @(negedge clk);
      echo[63-k] = sdo;
      sclk_rise = 1'b0; tsin = 1'b0;
    end
  endtask

  task automatic tail_bit();
    @(negedge clk); sclk_rise = 1'b1; tsin = 1'b0;
    @(negedge clk); sclk_rise = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_down();
    @(negedge clk); pdn = 1'b1;
    @(negedge clk);
    chk("R8 sdo_oe in power-down", 64'(sdo_oe), 64'd0);
    idle(2);
    pdn = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] e;
    logic        sc [21];
    logic        fs [21];
    rst_n = 1'b0; pdn = 1'b0; dc = 1'b0; sclk_rise = 1'b0; tsin = 1'b0; sdi = 1'b0;
    idle(4);
    chk("R8 sdo_oe in reset", 64'(sdo_oe), 64'd0);
    chk("R9 sclk_out in reset", 64'(sclk_out), 64'd0);
    chk("R9 fsync_out in reset", 64'(fsync_out), 64'd0);
    chk("R10 slot_start in reset", 64'(slot_start), 64'd0);
    rst_n = 1'b1;
    idle(4);
    chk("R8 sdo_oe after reset", 64'(sdo_oe), 64'd1);
    chk("R2 sdo idle after reset", 64'(sdo), 64'd0);

    // table walk: echoes of consistent oscillator-clocked words (R1, R2)
    for (int i = 0; i < 4; i++) begin
      send_frame(TAB_TX[i], e);
      chk($sformatf("R1 R2 table echo %0d", i), e, TAB_EXP[i]);
    end

    // fast acknowledgement and lock (R3, R6, R7)
    send_frame(64'h2001_FFFF_0000_FFFF, e);
    chk("R2 echo before flag", e, 64'h0001_FFFF_0000_FFFF);
    send_frame(64'hFFFF_FFFF_FFFF_FFFF, e);
    chk("R3 next-frame flag echo", e, 64'h2001_FFFF_0000_FFFF);
    chk("R7 driver on before extra clock", 64'(sdo_oe), 64'd1);
    tail_bit();
    chk("R7 driver off after extra clock", 64'(sdo_oe), 64'd0);
    send_frame(64'hFFFF_FFFF_FFFF_FFFF, e);
    chk("R7 driver stays off", 64'(sdo_oe), 64'd0);

    // slave data mode, ignored master bit (R6, R10, R11)
    @(negedge clk); dc = 1'b1; sclk_rise = 1'b1; tsin = 1'b1;
    @(negedge clk); sclk_rise = 1'b0;
    chk("R10 slot on first edge", 64'(slot_start), 64'd1);
    chk("R11 driver off in data mode", 64'(sdo_oe), 64'd0);
    @(negedge clk);
    chk("R10 slot single pulse", 64'(slot_start), 64'd0);
    sclk_rise = 1'b1;
    @(negedge clk); sclk_rise = 1'b0;
    chk("R10 no slot on held tsin", 64'(slot_start), 64'd0);
    tsin = 1'b0; sclk_rise = 1'b1;
    @(negedge clk); tsin = 1'b1;
    @(negedge clk); sclk_rise = 1'b0; tsin = 1'b0;
    chk("R10 slot on new rise", 64'(slot_start), 64'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 ignored word left slave mode", 64'(sclk_out), 64'd0);
    end
    @(negedge clk); dc = 1'b0;
    idle(2);
    chk("R11 driver back in control mode", 64'(sdo_oe), 64'd1);
    send_frame(64'h0001_FFFF_0000_FFFF, e);
    chk("R11 flag cleared config kept", e, 64'h0001_FFFF_0000_FFFF);

    // slow acknowledgement with serial clock source (R4)
    send_frame(64'h0008_0000_0000_0001, e);
    chk("R2 echo before source change", e, 64'h0001_FFFF_0000_FFFF);
    send_frame(64'h2008_0000_0000_0001, e);
    chk("R4 echo of source word", e, 64'h0008_0000_0000_0001);
    send_frame(64'h1234_5678_9ABC_DEF0, e);
    chk("R4 flag held before timer", e, 64'h0008_0000_0000_0001);
    idle(220);
    send_frame(64'h1234_5678_9ABC_DEF0, e);
    chk("R4 flag after timer", e, 64'h2008_0000_0000_0001);
    tail_bit();
    chk("R7 driver off after slow lock", 64'(sdo_oe), 64'd0);

    // power-down clear and timer restart (R8, R5)
    power_down();
    chk("R8 driver on after power-down", 64'(sdo_oe), 64'd1);
    send_frame(64'h0008_0000_0000_0000, e);
    chk("R8 cleared echo", e, 64'h0);
    idle(300);
    send_frame(64'h0048_0000_0000_0000, e);
    chk("R2 echo of first source word", e, 64'h0008_0000_0000_0000);
    send_frame(64'h2048_0000_0000_0000, e);
    chk("R2 echo of rate change", e, 64'h0048_0000_0000_0000);
    idle(100);
    send_frame(64'h0, e);
    chk("R5 timer restarted on rate change", e, 64'h0048_0000_0000_0000);
    idle(250);
    send_frame(64'h0, e);
    chk("R5 flag after restarted timer", e, 64'h2048_0000_0000_0000);

    // master data mode (R9)
    power_down();
    send_frame(64'h0004_0000_0000_0000, e);
    chk("R8 echo zero before master word", e, 64'h0);
    @(negedge clk); dc = 1'b1;
    for (int k = 0; k < 21; k++) begin
      @(negedge clk);
      sc[k] = sclk_out; fs[k] = fsync_out;
    end
    chk("R9 lead-in low", {62'd0, sc[0], fs[0]}, 64'b00);
    chk("R9 first rise no sync", {62'd0, sc[1], fs[1]}, 64'b10);
    chk("R9 low between rises", {62'd0, sc[2], fs[2]}, 64'b00);
    chk("R9 sync with second rise", {62'd0, sc[3], fs[3]}, 64'b11);
    chk("R9 sync held one period", {62'd0, sc[4], fs[4]}, 64'b01);
    chk("R9 sync drops", {62'd0, sc[5], fs[5]}, 64'b10);
    chk("R9 no sync before repeat", {62'd0, sc[17], fs[17]}, 64'b10);
    chk("R9 sync repeats", {62'd0, sc[19], fs[19]}, 64'b11);
    chk("R11 driver off as master", 64'(sdo_oe), 64'd0);

    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule